// File: doc/BRIEF.md
# Expander Management-Bus Command Engine

This block is a bus master for a two-wire management link (MDC clock, MDIO data) that talks to an external GPIO-expander chip. Software writes a 32-bit command word holding the target device address, the register number, the operation and, for writes, 16 bits of data, with the go bit set. The engine then runs one clause-22 style transaction on the bus. For a read, it places the returned data in the upper half of the command word. The go bit clears when the transaction ends, whether it finished normally or was cut short.

Two more registers shape the traffic. A small configuration register picks the length of the preamble of ones. A device register holds an enable bit, the expander's 5-bit address and a two-bit MDC rate; reading it back also shows a ready flag. The engine gives no failure indication. A transaction that runs past a cycle budget, or loses its enable, simply ends with the go bit cleared.

Top module: `expander_miim_master`

## Requirements
- R1: After reset, `cmd_word`, `cfg_word` and `dev_word` read zero, `mdc` is low and `mdio_oe` is low.
- R2: A command write made while the enable bit (`dev_word[0]`) is 0 stores the word with bit 0 forced to 0. No bus activity follows.
- R3: A command with bit 0 set and enable on starts a frame one cycle after the write. After the preamble, the frame sends, MSB first: 01, the opcode (10 when bit 1 is 0 for a read, 01 when bit 1 is 1 for a write), the device address from bits [6:2], the register number from bits [11:7], turnaround 10, and data bits [31:16]. `mdio_o` changes only when MDC falls, and each bit opens with its low half.
- R4: `cfg_wdata` (readable as `cfg_word`) selects the preamble of ones: 0 gives 16 bits, 1 gives 32, 2 gives none, 3 gives 8. The value is taken when a frame starts.
- R5: Rate field `dev_word[9:8]`=r sets the MDC half period to max(1, BASE_HALF>>r) clock cycles; rates 0..3 map to 2.5/5/10/20 MHz when BASE_HALF is 50 at a 250 MHz clock. The rate is taken when a frame starts.
- R6: On a read, `mdio_oe` is low from the first turnaround bit to the end. The 16 data bits are sampled where MDC rises, MSB first, and written to `cmd_word[31:16]` when the frame ends.
- R7: Bit 0 of `cmd_word` clears in the cycle MDC returns low after the last bit's high half. A frame of N bits keeps it set for exactly 2·N·half clock cycles.
- R8: Command writes made while a frame is in flight are ignored.
- R9: If a frame is still running TIMEOUT_CYC cycles after it started, it is dropped. Bit 0 clears, MDC goes low, MDIO is released, and `cmd_word[31:16]` keeps its earlier value.
- R10: Clearing the enable bit during a frame drops the frame one cycle later, with the same outcome as R9.
- R11: `dev_word` reads {rate[9:8], 0 at bit 7, ready at bit 6, address [5:1], enable [0]}. Ready is 1 exactly when enable is on and no frame is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_wdata | input | 32 | Command word to write |
| cmd_word | output | 32 | Command register readback |
| cfg_wr | input | 1 | Preamble configuration write strobe |
| cfg_wdata | input | 2 | Preamble length code |
| cfg_word | output | 2 | Preamble configuration readback |
| dev_wr | input | 1 | Device register write strobe |
| dev_wdata | input | 10 | Device register word (bits 7:6 read-only) |
| dev_word | output | 10 | Device register readback with ready flag |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO value driven out |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO value sampled from the pin |

## Verification
Two events can compete in the same cycle. The first is software touching the registers while a frame is shifting: a second command write and a cleared enable both land mid-frame. The second is the cycle budget running out before the last bit finishes. The bench schedules the command rewrite and the enable drop at fixed cycle offsets into running frames, and it picks a slow rate with a long preamble so the budget expires mid-read. A behavioural model predicts the per-cycle MDC, MDIO and register values and is compared every clock; explicit checks confirm that the stored address and register fields survive, that the read data field is untouched after an abandoned read, and that the go bit lasts exactly the expected number of cycles.

// File: rtl/mm_pkg.sv
package mm_pkg;
  localparam int BODY_W = 32;
  localparam int VEC_W  = 64;
  localparam int DATA_W = 16;
  localparam int CNT_W  = 7;

  typedef enum logic [1:0] {
    PRE_16   = 2'd0,
    PRE_32   = 2'd1,
    PRE_NONE = 2'd2,
    PRE_8    = 2'd3
  } pre_sel_e;

  function automatic int unsigned pre_len(input logic [1:0] sel);
    case (pre_sel_e'(sel))
      PRE_16:   return 16;
      PRE_32:   return 32;
      PRE_NONE: return 0;
      default:  return 8;
    endcase
  endfunction
endpackage

// File: rtl/mm_frame.sv
module mm_frame
  import mm_pkg::*;
(
  input  logic              op_wr,
  input  logic [4:0]        phy,
  input  logic [4:0]        regn,
  input  logic [DATA_W-1:0] wdat,
  input  logic [1:0]        pre_sel,
  output logic [VEC_W-1:0]  bits_v,
  output logic [VEC_W-1:0]  drv_v,
  output logic [CNT_W-1:0]  nbits
);
  logic [BODY_W-1:0] body, mask;
  logic [5:0]        lsh;

  always_comb begin
    body   = {2'b01, (op_wr ? 2'b01 : 2'b10), phy, regn, 2'b10, wdat};
    mask   = op_wr ? '1 : {{14{1'b1}}, {(BODY_W-14){1'b0}}};
    lsh    = 6'(BODY_W - pre_len(pre_sel));
    bits_v = {{(VEC_W-BODY_W){1'b1}}, body} << lsh;
    drv_v  = {{(VEC_W-BODY_W){1'b1}}, mask} << lsh;
    nbits  = CNT_W'(pre_len(pre_sel) + BODY_W);
  end
endmodule

// File: rtl/mm_tick.sv
module mm_tick #(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          run,
  input  logic [CW-1:0] lim,
  output logic          tick
);
  logic [CW-1:0] cnt;

  assign tick = run && (cnt == lim - CW'(1));

  always_ff @(posedge clk) begin
    if (rst || clr || !run) cnt <= '0;
    else if (tick)          cnt <= '0;
    else                    cnt <= cnt + CW'(1);
  end
endmodule

// File: rtl/mm_capture.sv
module mm_capture #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         shift_en,
  input  logic         din,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst || clr)    q <= '0;
    else if (shift_en) q <= {q[W-2:0], din};
  end
endmodule

// File: rtl/expander_miim_master.sv
module expander_miim_master
  import mm_pkg::*;
#(
  parameter int BASE_HALF   = 50,
  parameter int TIMEOUT_CYC = 4096
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cmd_wr,
  input  logic [31:0] cmd_wdata,
  output logic [31:0] cmd_word,
  input  logic        cfg_wr,
  input  logic [1:0]  cfg_wdata,
  output logic [1:0]  cfg_word,
  input  logic        dev_wr,
  input  logic [9:0]  dev_wdata,
  output logic [9:0]  dev_word,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int HW = $clog2(BASE_HALF + 1);
  localparam int TW = $clog2(TIMEOUT_CYC + 1);

  function automatic logic [HW-1:0] half_of(input logic [1:0] r);
    logic [HW-1:0] v;
    v = HW'(BASE_HALF >> r);
    if (v == '0) v = HW'(1);
    return v;
  endfunction

  logic              busy_q, hi_q, mdc_q, en_q;
  logic [31:0]       cmd_q;
  logic [1:0]        pre_q, rate_q;
  logic [4:0]        addr_q;
  logic [HW-1:0]     half_q;
  logic [VEC_W-1:0]  sh_q, drv_q;
  logic [CNT_W-1:0]  left_q;
  logic [TW-1:0]     tmo_q;

  logic              start, tick, tmo_hit, finish_now, abort_now, samp;
  logic [VEC_W-1:0]  fr_bits, fr_drv;
  logic [CNT_W-1:0]  fr_n;
  logic [DATA_W-1:0] cap_q;
  logic              unused_dev;

  assign unused_dev = ^dev_wdata[7:6];

  assign start      = !busy_q && cmd_wr && cmd_wdata[0] && en_q;
  assign tmo_hit    = (tmo_q == TW'(TIMEOUT_CYC - 1));
  assign finish_now = busy_q && tick && hi_q && (left_q == CNT_W'(1));
  assign abort_now  = busy_q && !finish_now && (!en_q || tmo_hit);
  assign samp       = busy_q && tick && !hi_q && !cmd_q[1] &&
                      (left_q <= CNT_W'(DATA_W));

  mm_frame u_frame (
    .op_wr   (cmd_wdata[1]),
    .phy     (cmd_wdata[6:2]),
    .regn    (cmd_wdata[11:7]),
    .wdat    (cmd_wdata[31:16]),
    .pre_sel (pre_q),
    .bits_v  (fr_bits),
    .drv_v   (fr_drv),
    .nbits   (fr_n)
  );

  mm_tick #(.CW(HW)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .clr  (start),
    .run  (busy_q),
    .lim  (half_q),
    .tick (tick)
  );

  mm_capture #(.W(DATA_W)) u_cap (
    .clk      (clk),
    .rst      (rst),
    .clr      (start),
    .shift_en (samp),
    .din      (mdio_i),
    .q        (cap_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      hi_q   <= 1'b0;
      mdc_q  <= 1'b0;
      en_q   <= 1'b0;
      cmd_q  <= '0;
      pre_q  <= '0;
      rate_q <= '0;
      addr_q <= '0;
      half_q <= HW'(1);
      sh_q   <= '0;
      drv_q  <= '0;
      left_q <= '0;
      tmo_q  <= '0;
    end else begin
      if (dev_wr) begin
        rate_q <= dev_wdata[9:8];
        addr_q <= dev_wdata[5:1];
        en_q   <= dev_wdata[0];
      end
      if (cfg_wr) pre_q <= cfg_wdata;

      if (!busy_q) begin
        if (cmd_wr) cmd_q <= {cmd_wdata[31:1], cmd_wdata[0] & en_q};
        if (start) begin
          busy_q <= 1'b1;
          half_q <= half_of(rate_q);
          sh_q   <= fr_bits;
          drv_q  <= fr_drv;
          left_q <= fr_n;
          hi_q   <= 1'b0;
          mdc_q  <= 1'b0;
          tmo_q  <= '0;
        end
      end else if (finish_now || abort_now) begin
        busy_q   <= 1'b0;
        cmd_q[0] <= 1'b0;
        if (finish_now && !cmd_q[1]) cmd_q[31:16] <= cap_q;
        mdc_q    <= 1'b0;
        hi_q     <= 1'b0;
        sh_q     <= '0;
        drv_q    <= '0;
      end else begin
        tmo_q <= tmo_q + TW'(1);
        if (tick) begin
          if (!hi_q) begin
            hi_q  <= 1'b1;
            mdc_q <= 1'b1;
          end else begin
            hi_q   <= 1'b0;
            mdc_q  <= 1'b0;
            sh_q   <= sh_q << 1;
            drv_q  <= drv_q << 1;
            left_q <= left_q - CNT_W'(1);
          end
        end
      end
    end
  end

  assign cmd_word = cmd_q;
  assign cfg_word = pre_q;
  assign dev_word = {rate_q, 1'b0, en_q && !busy_q, addr_q, en_q};
  assign mdc      = mdc_q;
  assign mdio_o   = sh_q[VEC_W-1];
  assign mdio_oe  = drv_q[VEC_W-1];

  // R7
  end_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_q) |-> (!mdc && !mdio_oe));

  // R8
  fields_hold_chk: assert property (@(posedge clk) disable iff (rst)
    busy_q |=> (cmd_q[15:1] == $past(cmd_q[15:1])));

  // R6
  read_release_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !cmd_q[1] && left_q <= CNT_W'(DATA_W + 2)) |-> !mdio_oe);

  // R5
  mdc_pace_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !tick && en_q && !tmo_hit) |=> $stable(mdc));

  // R10
  enable_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !en_q |=> !busy_q);

  // R9
  budget_chk: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> (tmo_q < TW'(TIMEOUT_CYC)));
endmodule

// File: tb/tb_expander_miim_master.sv
`timescale 1ns/1ps
module tb_expander_miim_master;
  localparam int BH  = 8;
  localparam int TMO = 900;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_wr = 1'b0, cfg_wr = 1'b0, dev_wr = 1'b0;
  logic [31:0] cmd_wdata = '0;
  logic [1:0]  cfg_wdata = '0;
  logic [9:0]  dev_wdata = '0;
  logic        mdio_i = 1'b1;
  logic [31:0] cmd_word;
  logic [1:0]  cfg_word;
  logic [9:0]  dev_word;
  logic        mdc, mdio_o, mdio_oe;

  always #2 clk = ~clk;

  expander_miim_master #(.BASE_HALF(BH), .TIMEOUT_CYC(TMO)) dut (
    .clk(clk), .rst(rst),
    .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata), .cmd_word(cmd_word),
    .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_word(cfg_word),
    .dev_wr(dev_wr), .dev_wdata(dev_wdata), .dev_word(dev_word),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  int checks = 0, fails = 0, cycles = 0;

  // behavioural reference state
  bit          m_act = 0, m_en = 0;
  int          m_t = 0, m_P = 0, m_h = 1, m_end = 0;
  logic [31:0] m_cmd = '0;
  logic [1:0]  m_pre = '0, m_rate = '0;
  logic [4:0]  m_addr = '0;
  logic [15:0] rdpat = '0;
  bit          p_rst = 1, p_cwr = 0, p_fwr = 0, p_dwr = 0;
  logic [31:0] p_cw = '0;
  logic [1:0]  p_fw = '0;
  logic [9:0]  p_dw = '0;

  function automatic int plen(input logic [1:0] s);
    case (s)
      2'd0: return 16;
      2'd1: return 32;
      2'd2: return 0;
      default: return 8;
    endcase
  endfunction

  function automatic bit exp_bit(input int i);
    logic [31:0] body;
    int j;
    if (i < m_P) return 1'b1;
    j = i - m_P;
    body = {2'b01, (m_cmd[1] ? 2'b01 : 2'b10), m_cmd[6:2], m_cmd[11:7],
            2'b10, m_cmd[31:16]};
    return body[31-j];
  endfunction

  function automatic bit exp_drive(input int i);
    return m_cmd[1] ? 1'b1 : (i < m_P + 14);
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    bit en_old;
    bit e_mdc, e_oe;
    int b;
    cycles++;
    if (p_rst) begin
      m_act = 0; m_cmd = '0; m_pre = '0; m_rate = '0; m_addr = '0; m_en = 0;
    end else begin
      en_old = m_en;
      if (m_act) begin
        m_t++;
        if (m_t == m_end) begin
          m_act = 0; m_cmd[0] = 1'b0;
          if (!m_cmd[1]) m_cmd[31:16] = rdpat;
        end else if (!en_old || m_t == TMO) begin
          m_act = 0; m_cmd[0] = 1'b0;
        end
      end else if (p_cwr) begin
        m_cmd = {p_cw[31:1], p_cw[0] & en_old};
        if (m_cmd[0]) begin
          m_act = 1; m_t = 0; m_P = plen(m_pre);
          m_h = BH >> m_rate;
          if (m_h == 0) m_h = 1;
          m_end = (m_P + 32) * 2 * m_h;
        end
      end
      if (p_fwr) m_pre = p_fw;
      if (p_dwr) begin
        m_rate = p_dw[9:8]; m_addr = p_dw[5:1]; m_en = p_dw[0];
      end
    end
    b = m_act ? m_t / (2 * m_h) : 0;
    if (!rst && !p_rst) begin
      e_mdc = m_act && ((m_t % (2 * m_h)) >= m_h);
      e_oe  = m_act && exp_drive(b);
      chk(mdc === e_mdc, "R5", "mdc", 32'(mdc), 32'(e_mdc));
      chk(mdio_oe === e_oe, "R6", "mdio_oe", 32'(mdio_oe), 32'(e_oe));
      if (e_oe)
        chk(mdio_o === exp_bit(b), (b < m_P) ? "R4" : "R3", "mdio_o",
            32'(mdio_o), 32'(exp_bit(b)));
      chk(cmd_word === m_cmd, "R7", "cmd_word", cmd_word, m_cmd);
      chk(dev_word === {m_rate, 1'b0, m_en && !m_act, m_addr, m_en}, "R11",
          "dev_word", 32'(dev_word), 32'({m_rate, 1'b0, m_en && !m_act, m_addr, m_en}));
      chk(cfg_word === m_pre, "R4", "cfg_word", 32'(cfg_word), 32'(m_pre));
    end
    if (m_act && !m_cmd[1] && b >= m_P + 16 && b < m_P + 32)
      mdio_i = rdpat[15 - (b - m_P - 16)];
    else
      mdio_i = 1'b1;
    p_rst = rst; p_cwr = cmd_wr; p_cw = cmd_wdata;
    p_fwr = cfg_wr; p_fw = cfg_wdata; p_dwr = dev_wr; p_dw = dev_wdata;
  end

  always @(posedge clk) begin
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  function automatic logic [31:0] mk(input logic [15:0] d, input logic [4:0] rg,
                                     input logic [4:0] ad, input bit wr, input bit go);
    return {d, 4'b0, rg, ad, wr, go};
  endfunction

  task automatic wr_cmd(input logic [31:0] w);
    @(posedge clk); #1; cmd_wr = 1'b1; cmd_wdata = w;
    @(posedge clk); #1; cmd_wr = 1'b0;
  endtask
  task automatic wr_cfg(input logic [1:0] w);
    @(posedge clk); #1; cfg_wr = 1'b1; cfg_wdata = w;
    @(posedge clk); #1; cfg_wr = 1'b0;
  endtask
  task automatic wr_dev(input logic [1:0] rate, input logic [4:0] ad, input bit en);
    @(posedge clk); #1; dev_wr = 1'b1; dev_wdata = {rate, 2'b00, ad, en};
    @(posedge clk); #1; dev_wr = 1'b0;
  endtask
  task automatic wait_done(output int n);
    n = 0;
    @(negedge clk);
    while (cmd_word[0] === 1'b1) begin n++; @(negedge clk); end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int n;
    logic [31:0] w;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(cmd_word === '0 && cfg_word === '0 && dev_word === '0, "R1", "regs after reset",
        cmd_word, 32'h0);
    chk(mdc === 1'b0 && mdio_oe === 1'b0, "R1", "bus after reset",
        32'({mdc, mdio_oe}), 32'h0);

    // R2 go without enable
    w = mk(16'h1234, 5'd3, 5'd4, 1'b1, 1'b1);
    wr_cmd(w);
    repeat (20) @(negedge clk);
    chk(cmd_word === {w[31:1], 1'b0}, "R2", "stored word", cmd_word, {w[31:1], 1'b0});
    chk(mdio_oe === 1'b0 && mdc === 1'b0, "R2", "bus idle", 32'({mdc, mdio_oe}), 32'h0);

    // R3 write, 16-bit preamble, fastest rate
    wr_cfg(2'd0);
    wr_dev(2'd3, 5'h0B, 1'b1);
    wr_cmd(mk(16'hA5C3, 5'h11, 5'h06, 1'b1, 1'b1));
    wait_done(n);
    chk(n == 48 * 2, "R7", "go duration rate3 pre16", 32'(n), 32'(96));

    // R6 read, 8-bit preamble, rate 2
    rdpat = 16'h3C96;
    wr_cfg(2'd3);
    wr_dev(2'd2, 5'h0B, 1'b1);
    wr_cmd(mk(16'h0000, 5'h02, 5'h1F, 1'b0, 1'b1));
    wait_done(n);
    chk(cmd_word[31:16] === 16'h3C96, "R6", "read data", 32'(cmd_word[31:16]), 32'h3C96);
    chk(n == 40 * 2 * 2, "R5", "go duration rate2 pre8", 32'(n), 32'(160));

    // R4 no preamble, write, rate 1
    wr_cfg(2'd2);
    wr_dev(2'd1, 5'h15, 1'b1);
    wr_cmd(mk(16'h8001, 5'h1E, 5'h01, 1'b1, 1'b1));
    wait_done(n);
    chk(n == 32 * 2 * 4, "R4", "go duration no preamble", 32'(n), 32'(256));

    // R4 32-bit preamble read, rate 1, with R8 rewrite mid-frame
    rdpat = 16'hF00D;
    wr_cfg(2'd1);
    w = mk(16'h5555, 5'h07, 5'h09, 1'b0, 1'b1);
    wr_cmd(w);
    repeat (40) @(posedge clk);
    wr_cmd(mk(16'hFFFF, 5'h1F, 5'h1F, 1'b1, 1'b1));
    wait_done(n);
    chk(cmd_word[15:1] === w[15:1], "R8", "fields kept", 32'(cmd_word[15:1]), 32'(w[15:1]));
    chk(cmd_word[31:16] === 16'hF00D, "R6", "read data pre32", 32'(cmd_word[31:16]), 32'hF00D);

    // R9 budget expiry: rate 0 with 32-bit preamble needs 1024 cycles
    rdpat = 16'h1111;
    wr_dev(2'd0, 5'h02, 1'b1);
    wr_cmd(mk(16'hBEEF, 5'h04, 5'h05, 1'b0, 1'b1));
    wait_done(n);
    chk(n == TMO, "R9", "abort cycle", 32'(n), 32'(TMO));
    chk(cmd_word[31:16] === 16'hBEEF, "R9", "data kept", 32'(cmd_word[31:16]), 32'hBEEF);

    // R7 rate 0 with 16-bit preamble fits the budget
    wr_cfg(2'd0);
    wr_cmd(mk(16'h0F0F, 5'h08, 5'h10, 1'b1, 1'b1));
    wait_done(n);
    chk(n == 48 * 16, "R7", "go duration rate0", 32'(n), 32'(768));

    // R10 enable dropped mid-frame
    wr_cmd(mk(16'h7777, 5'h01, 5'h02, 1'b1, 1'b1));
    repeat (100) @(posedge clk);
    wr_dev(2'd0, 5'h02, 1'b0);
    repeat (3) @(negedge clk);
    chk(cmd_word[0] === 1'b0 && mdc === 1'b0 && mdio_oe === 1'b0, "R10", "dropped",
        32'({cmd_word[0], mdc, mdio_oe}), 32'h0);
    chk(dev_word[6] === 1'b0, "R11", "ready off when disabled", 32'(dev_word[6]), 32'h0);
    wr_dev(2'd2, 5'h02, 1'b1);
    @(negedge clk);
    chk(dev_word[6] === 1'b1, "R11", "ready on", 32'(dev_word[6]), 32'h1);

    repeat (10) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule